// File: doc/BRIEF.md
# Automatic Baud Rate Detector

This block times a sync character on an asynchronous serial receive line and leaves a divisor that a baud rate generator can load as it stands. The host arms the block. It then waits for a start bit. It runs a prescaled counter from the first low-to-high transition of the line after that start bit up to the fifth such transition. For a 0x55 character the fifth transition is the one into the stop bit. The span therefore covers four low bits and four high bits, so any difference between low and high widths cancels out. The counter runs at one eighth of the rate that the generator uses for normal traffic, so eight bit times at that slower rate give one bit period at the generator's rate.

While the block is armed it reports busy. Busy holds the receive state machine in idle and blocks transmit writes. When the measurement ends, the block disarms itself and raises a done flag. The character received during the measurement is a dummy and is not passed on. An optional break-wake mode skips one low pulse, the break, before the measurement starts. The counter is always the full count width, whatever generator mode is in use. If the high byte of the result is zero, the value also fits an 8-bit generator.

Top module: `autobaud_meter`

## Requirements
- R1: After reset, count_q is zero and done_q, ovf_q and busy_q are all low.
- R2: A write of arm_wdata=1 through arm_wr while idle clears count_q and raises busy_q on the next clock edge. busy_q stays high until the measurement finishes or is aborted.
- R3: Counting starts on the first rising edge of the synchronised line after a falling edge (start bit), and stops on the fifth rising edge. With D clock cycles between the first and fifth rising edges of rx_in, the final count_q is floor((D-1)/div) modulo 2^CNT_W. For a 0x55 character of B clocks per bit, D = 8B.
- R4: rate_sel is captured at arming and sets the divider div: 00 gives DIV_SLOW (default 512), 01 and 10 give DIV_MID (default 128), and 11 gives DIV_FAST (default 32).
- R5: On the fifth rising edge, busy_q falls and done_q rises on the same clock edge. count_q then holds until the next arming.
- R6: When the count rolls over from all ones to zero, ovf_q is set and stays set. Measurement continues, and busy_q stays high.
- R7: A pulse on ovf_wr loads ovf_wdata into ovf_q. A rollover in the same cycle takes priority and sets the flag.
- R8: A pulse on done_ack clears done_q. A completion in the same cycle takes priority.
- R9: A write of arm_wdata=0 while armed returns the block to idle on the next edge without raising done_q. count_q then holds its value whatever the line does.
- R10: tx_wr_ok follows tx_wr_req while idle and is low while busy_q is high.
- R11: If wake_mode is high at arming, the first low pulse (a falling edge followed by a rising edge) is skipped. The measurement then applies to the character that follows it.
- R12: rx_in passes through two synchronising flops before edge detection. A state change caused by a line edge therefore appears at the outputs on the third clock edge after the edge is sampled.
- R13: A write of arm_wdata=1 while already armed is ignored and does not restart or clear the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Value written to the arm bit |
| rate_sel | input | 2 | Counter clock select, captured at arming |
| wake_mode | input | 1 | Skip one break pulse before measuring |
| done_ack | input | 1 | Clears done_q |
| ovf_wr | input | 1 | Write strobe for the overflow flag |
| ovf_wdata | input | 1 | Value written to the overflow flag |
| tx_wr_req | input | 1 | Transmit write request from the host |
| count_q | output | CNT_W | Measured divisor count |
| done_q | output | 1 | Measurement complete |
| ovf_q | output | 1 | Sticky counter rollover flag |
| busy_q | output | 1 | Armed; holds the receiver idle and blocks transmit |
| tx_wr_ok | output | 1 | Transmit write allowed |

## Verification
Most internal faults show within a clock or two on one of the outputs. A prescaler that runs at the wrong rate moves count_q away from the reference within one divider period. A wrong edge count changes the clock edge on which done_q rises. A wrong state makes busy_q or tx_wr_ok differ from the model on the next edge. The bench keeps a cycle-by-cycle behavioural model and compares every output on every clock. It also checks the final divisor against the closed-form value for each rate, each break mode and the rollover case.

// File: rtl/autobaud_meter.sv
module autobaud_meter #(
  parameter int CNT_W    = 16,
  parameter int DIV_SLOW = 512,
  parameter int DIV_MID  = 128,
  parameter int DIV_FAST = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             arm_wr,
  input  logic             arm_wdata,
  input  logic [1:0]       rate_sel,
  input  logic             wake_mode,
  input  logic             done_ack,
  input  logic             ovf_wr,
  input  logic             ovf_wdata,
  input  logic             tx_wr_req,
  output logic [CNT_W-1:0] count_q,
  output logic             done_q,
  output logic             ovf_q,
  output logic             busy_q,
  output logic             tx_wr_ok
);

  localparam int PRE_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);
  localparam logic [PRE_W-1:0] LIM_MID  = PRE_W'(DIV_MID - 1);
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_BRK_LO, ST_BRK_HI, ST_START, ST_RISE1, ST_MEAS
  } st_t;

  st_t              st_q;
  logic             rx_m, rx_s, rx_p;
  logic [1:0]       rate_q;
  logic [PRE_W-1:0] pre_q, lim;
  logic [2:0]       rises_q;
  logic             rise, fall, tick, arm_go, abort, last_edge, run, wrap, first_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_m, rx_s, rx_p} <= 3'b111;
    else        {rx_m, rx_s, rx_p} <= {rx_in, rx_m, rx_s};

  assign rise = rx_s & ~rx_p;
  assign fall = ~rx_s & rx_p;

  always_comb
    case (rate_q)
      2'b00:   lim = LIM_SLOW;
      2'b11:   lim = LIM_FAST;
      default: lim = LIM_MID;
    endcase

  assign tick       = (pre_q == lim);
  assign arm_go     = arm_wr & arm_wdata & (st_q == ST_IDLE);
  assign abort      = arm_wr & ~arm_wdata & (st_q != ST_IDLE);
  assign first_rise = (st_q == ST_RISE1) & rise & ~abort;
  assign last_edge  = (st_q == ST_MEAS) & rise & (rises_q == 3'd4);
  assign run        = (st_q == ST_MEAS) & ~last_edge & ~abort;
  assign wrap       = run & tick & (count_q == '1);
  assign busy_q     = (st_q != ST_IDLE);
  assign tx_wr_ok   = tx_wr_req & ~busy_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rate_q <= 2'b00;
    end else if (arm_go) begin
      st_q   <= wake_mode ? ST_BRK_LO : ST_START;
      rate_q <= rate_sel;
    end else if (abort) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_BRK_LO: if (fall) st_q <= ST_BRK_HI;
        ST_BRK_HI: if (rise) st_q <= ST_START;
        ST_START:  if (fall) st_q <= ST_RISE1;
        ST_RISE1:  if (rise) st_q <= ST_MEAS;
        ST_MEAS:   if (last_edge) st_q <= ST_IDLE;
        default:   st_q <= st_q;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count_q <= '0;
      pre_q   <= '0;
      rises_q <= '0;
    end else if (arm_go || first_rise) begin
      count_q <= '0;
      pre_q   <= '0;
      rises_q <= 3'd1;
    end else if (run) begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick) count_q <= count_q + CNT_W'(1);
      if (rise) rises_q <= rises_q + 3'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   done_q <= 1'b0;
    else if (last_edge && !abort) done_q <= 1'b1;
    else if (done_ack)            done_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ovf_q <= 1'b0;
    else if (wrap)   ovf_q <= 1'b1;
    else if (ovf_wr) ovf_q <= ovf_wdata;

  // R5
  done_ends_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (!busy_q && $past(busy_q)));

  // R2
  arm_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (count_q == '0));

  // R6
  ovf_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_q) && !$past(ovf_wr)) |-> busy_q);

  // R9
  abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arm_wr && !arm_wdata && busy_q) |-> (!busy_q && !$rose(done_q)));

  // R5
  idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q)) |-> $stable(count_q));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && (count_q != $past(count_q)))
      |-> ((count_q == $past(count_q) + CNT_W'(1)) || (count_q == '0)));

endmodule

// File: tb/sim_autobaud_meter.sv
module sim_autobaud_meter;
  localparam int CW = 10;
  localparam int DS = 32;
  localparam int DM = 8;
  localparam int DF = 2;

  logic clk = 0, rst_n = 0, rx_in = 1, arm_wr = 0, arm_wdata = 0, wake_mode = 0;
  logic done_ack = 0, ovf_wr = 0, ovf_wdata = 0, tx_wr_req = 0;
  logic [1:0] rate_sel = 0;
  logic [CW-1:0] count_q;
  logic done_q, ovf_q, busy_q, tx_wr_ok;

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  autobaud_meter #(.CNT_W(CW), .DIV_SLOW(DS), .DIV_MID(DM), .DIV_FAST(DF)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .arm_wr(arm_wr), .arm_wdata(arm_wdata),
    .rate_sel(rate_sel), .wake_mode(wake_mode), .done_ack(done_ack), .ovf_wr(ovf_wr),
    .ovf_wdata(ovf_wdata), .tx_wr_req(tx_wr_req), .count_q(count_q), .done_q(done_q),
    .ovf_q(ovf_q), .busy_q(busy_q), .tx_wr_ok(tx_wr_ok));

  int m_st = 0, m_div = DS, m_pre = 0, m_cnt = 0, m_rises = 0;
  bit m_done = 0, m_ovf = 0;
  bit hist[$];

  function automatic int div_of(logic [1:0] s);
    case (s)
      2'b00:   return DS;
      2'b11:   return DF;
      default: return DM;
    endcase
  endfunction

  function automatic int exp_cnt(int b, int d);
    return ((8 * b - 1) / d) % (1 << CW);
  endfunction

  always @(posedge clk) begin
    bit rise, fall, fin, hw, ab;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pre = 0; m_rises = 0; m_done = 0; m_ovf = 0; m_div = DS;
      hist = '{1'b1, 1'b1, 1'b1, 1'b1};
    end else begin
      hist.push_back(rx_in);
      void'(hist.pop_front());
      rise = hist[1] && !hist[0];
      fall = !hist[1] && hist[0];
      fin = 0; hw = 0;
      ab = arm_wr && !arm_wdata && m_st != 0;
      if (m_st == 0) begin
        if (arm_wr && arm_wdata) begin
          m_st = wake_mode ? 1 : 3; m_cnt = 0; m_pre = 0; m_rises = 1; m_div = div_of(rate_sel);
        end
      end else if (ab) m_st = 0;
      else case (m_st)
        1: if (fall) m_st = 2;
        2: if (rise) m_st = 3;
        3: if (fall) m_st = 4;
        4: if (rise) begin m_st = 5; m_cnt = 0; m_pre = 0; m_rises = 1; end
        5: if (rise && m_rises == 4) begin m_st = 0; fin = 1; end
           else begin
             if (rise) m_rises++;
             if (m_pre == m_div - 1) begin
               m_pre = 0;
               if (m_cnt == (1 << CW) - 1) begin hw = 1; m_cnt = 0; end
               else m_cnt++;
             end else m_pre++;
           end
        default: ;
      endcase
      if (fin) m_done = 1; else if (done_ack) m_done = 0;
      if (hw) m_ovf = 1; else if (ovf_wr) m_ovf = ovf_wdata;
    end
  end

  // R12 cycle agreement with the behavioural model, every clock
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      n_chk++;
      if (busy_q !== (m_st != 0) || done_q !== m_done || ovf_q !== m_ovf ||
          count_q !== CW'(m_cnt) || tx_wr_ok !== (tx_wr_req && m_st == 0)) begin
        n_bad++;
        if (n_bad <= 10)
          $display("FAIL R12 model: busy %0b/%0b done %0b/%0b ovf %0b/%0b count %0d/%0d txok %0b/%0b (actual/expected)",
                   busy_q, m_st != 0, done_q, m_done, ovf_q, m_ovf, count_q, m_cnt,
                   tx_wr_ok, tx_wr_req && m_st == 0);
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(bit v, int n);
    rx_in = v;
    tick_n(n);
  endtask

  task automatic arm(bit wake, logic [1:0] sel);
    rate_sel = sel; wake_mode = wake; arm_wr = 1; arm_wdata = 1;
    tick_n(1);
    arm_wr = 0;
  endtask

  task automatic ack();
    done_ack = 1;
    tick_n(1);
    done_ack = 0;
  endtask

  task automatic send_sync(int b, bit with_stop);
    drive(0, b);
    for (int i = 0; i < 8; i++) drive((8'h55 >> i) & 1, b);
    if (with_stop) drive(1, 2 * b);
  endtask

  initial begin
    int held;
    tick_n(3);
    rst_n = 1;
    tick_n(1);
    chk(count_q == 0, "R1 count after reset", count_q, 0);
    chk(!done_q && !ovf_q, "R1 flags after reset", {done_q, ovf_q}, 0);
    chk(!busy_q, "R1 busy after reset", busy_q, 0);

    tx_wr_req = 1;
    tick_n(1);
    chk(tx_wr_ok == 1, "R10 tx allowed idle", tx_wr_ok, 1);
    arm(0, 2'b11);
    chk(busy_q == 1, "R2 busy after arm", busy_q, 1);
    chk(count_q == 0, "R2 count cleared", count_q, 0);
    chk(tx_wr_ok == 0, "R10 tx blocked busy", tx_wr_ok, 0);
    tx_wr_req = 0;
    send_sync(20, 1);
    chk(done_q == 1, "R5 done raised", done_q, 1);
    chk(busy_q == 0, "R5 busy dropped", busy_q, 0);
    chk(count_q == exp_cnt(20, DF), "R3 count sel 11", count_q, exp_cnt(20, DF));
    tick_n(30);
    chk(count_q == exp_cnt(20, DF), "R5 count held", count_q, exp_cnt(20, DF));
    ack();
    chk(done_q == 0, "R8 done cleared", done_q, 0);

    for (int i = 0; i < 3; i++) begin
      int b;
      b = (i == 0) ? 40 : 16;
      arm(0, 2'(i));
      send_sync(b, 1);
      chk(count_q == exp_cnt(b, div_of(2'(i))), $sformatf("R4 count sel %0d", i),
          count_q, exp_cnt(b, div_of(2'(i))));
      ack();
    end

    arm(0, 2'b11);
    send_sync(20, 0);
    rx_in = 1;
    tick_n(1);
    chk(done_q == 0, "R12 done after 1 edge", done_q, 0);
    tick_n(1);
    chk(done_q == 0, "R12 done after 2 edges", done_q, 0);
    tick_n(1);
    chk(done_q == 1, "R12 done after 3 edges", done_q, 1);
    tick_n(40);
    ack();

    arm(0, 2'b11);
    send_sync(300, 1);
    chk(ovf_q == 1, "R6 overflow flag", ovf_q, 1);
    chk(count_q == exp_cnt(300, DF), "R6 wrapped count", count_q, exp_cnt(300, DF));
    ack();

    ovf_wr = 1; ovf_wdata = 0;
    tick_n(1);
    ovf_wr = 0;
    chk(ovf_q == 0, "R7 host clear", ovf_q, 0);
    ovf_wr = 1; ovf_wdata = 1;
    tick_n(1);
    ovf_wr = 0;
    chk(ovf_q == 1, "R7 host set", ovf_q, 1);
    tick_n(5);
    chk(ovf_q == 1, "R7 sticky", ovf_q, 1);
    ovf_wr = 1; ovf_wdata = 0;
    tick_n(1);
    ovf_wr = 0;

    arm(0, 2'b11);
    drive(0, 20);
    drive(1, 20);
    drive(0, 5);
    arm_wr = 1; arm_wdata = 0;
    tick_n(1);
    arm_wr = 0;
    chk(busy_q == 0, "R9 abort idle", busy_q, 0);
    chk(done_q == 0, "R9 no done", done_q, 0);
    held = count_q;
    drive(1, 10);
    drive(0, 10);
    drive(1, 10);
    chk(count_q == held, "R9 count held", count_q, held);
    chk(done_q == 0, "R9 still no done", done_q, 0);

    arm(1, 2'b11);
    drive(0, 240);
    drive(1, 40);
    send_sync(20, 1);
    chk(done_q == 1, "R11 done after break", done_q, 1);
    chk(count_q == exp_cnt(20, DF), "R11 count after break", count_q, exp_cnt(20, DF));
    ack();

    arm(0, 2'b11);
    drive(0, 20);
    drive(1, 5);
    arm_wr = 1; arm_wdata = 1;
    tick_n(1);
    arm_wr = 0;
    chk(busy_q == 1, "R13 still armed", busy_q, 1);
    tick_n(14);
    for (int i = 1; i < 8; i++) drive((8'h55 >> i) & 1, 20);
    drive(1, 40);
    chk(count_q == exp_cnt(20, DF), "R13 rearm ignored", count_q, exp_cnt(20, DF));
    ack();

    tick_n(5);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog actual timeout expected completion");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule